// File: doc/BRIEF.md
# Adaptive Duty Pulse-Skip Controller

This block drives the gate of the power switch in a digitally controlled DC-DC converter that powers a digital load. The converter runs in discontinuous conduction and, in steady state, near 1.5 MHz. A switching-cycle tick marks the start of each cycle. On that tick the block captures a 3-bit error code, which comes either from a critical-path delay monitor or from a quantized output-voltage error. For the rest of the cycle that captured code alone sets the gate pulse.

A zero code means the output is at or above target, so the cycle's pulse is dropped. A non-zero code produces a pulse that starts with the cycle. Its width grows in steps of one sixteenth of the switching period, so the pulse is wider when the error is larger. A parameterised upper code caps the widest pulse, which keeps every permitted duty inside discontinuous conduction. Below the cap the block acts like a PWM controller with a few duty levels. At the bottom it falls back to pure pulse skipping.

Top module: `adp_skip_ctrl`

## Requirements
- R1: While reset is asserted, and after reset until the first tick has been taken, `gate_o` is low. An asynchronous reset drives it low at once, even in the middle of a pulse.
- R2: A tick arrives with code c, where 1 <= c <= MAX_CODE, and the first tick since reset has already passed. `gate_o` goes high on the clock edge that samples the tick and stays high for exactly c*STEP_CLKS clocks. `err_code_i` is unsigned, and a larger value means a larger error.
- R3: A tick with code 0 keeps `gate_o` low for the whole of that cycle.
- R4: Codes above MAX_CODE are treated as MAX_CODE, so no pulse lasts more than MAX_CODE*STEP_CLKS clocks.
- R5: Changes on `err_code_i` between ticks have no effect on the pulse in progress: not on its width and not on its start.
- R6: The first tick after reset is skipped whatever its code.
- R7: When no further tick arrives, `gate_o` falls at the end of the current pulse and stays low; it never rises without a tick.
- R8: A tick that arrives before the period has run out starts a new cycle from count 0. The new pulse width is counted from that tick, and the old one is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock (STEP_CLKS*16 clocks per switching period) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cycle_tick_i | input | 1 | One-clock strobe marking the start of a switching cycle |
| err_code_i | input | 3 | Error code, 0 = skip, 1..7 = duty in sixteenths |
| gate_o | output | 1 | Power switch gate drive, registered |

## Verification
A wrong captured duty or a stale limit shows as a pulse edge off by whole clocks, or as a pulse on a cycle that should have been skipped. In either case the fault appears at `gate_o` within the first cycle after the faulty tick. A counter that fails to saturate or to restart shows as a second rising edge with no tick, or as a truncated pulse after an early tick. The bench compares `gate_o` on every clock against a remaining-width model, so any such divergence is flagged on the clock where it first appears.

// File: rtl/adp_pkg.sv
`timescale 1ns/1ps
package adp_pkg;
  localparam int CODE_W     = 3;
  localparam int DUTY_STEPS = 16;
  typedef logic [CODE_W-1:0] err_code_t;
endpackage

// File: rtl/adp_cycle_timer.sv
`timescale 1ns/1ps
module adp_cycle_timer #(
  parameter int PERIOD_CLKS = 80,
  parameter int CNT_W       = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  // saturate at period end so a missing tick never wraps into a new pulse
  always_comb begin
    if (tick_i)                              cnt_nxt_o = '0;
    else if (cnt_q == CNT_W'(PERIOD_CLKS))   cnt_nxt_o = cnt_q;
    else                                     cnt_nxt_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CNT_W'(PERIOD_CLKS);
    else         cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/adp_duty_map.sv
`timescale 1ns/1ps
module adp_duty_map
  import adp_pkg::*;
#(
  parameter int STEP_CLKS = 5,
  parameter int MAX_CODE  = 7,
  parameter int CNT_W     = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  err_code_t        code_i,
  output logic [CNT_W-1:0] lim_nxt_o
);
  logic             armed_q;
  logic [CNT_W-1:0] lim_q;
  err_code_t        code_clamped;
  logic [CNT_W-1:0] lim_new;

  // clamp keeps the widest pulse inside discontinuous conduction
  assign code_clamped = (int'(code_i) > MAX_CODE) ? CODE_W'(MAX_CODE) : code_i;
  // first tick after reset is forced to skip
  assign lim_new      = armed_q ? CNT_W'(int'(code_clamped) * STEP_CLKS) : '0;
  assign lim_nxt_o    = tick_i ? lim_new : lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q   <= '0;
      armed_q <= 1'b0;
    end else if (tick_i) begin
      lim_q   <= lim_new;
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/adp_gate_gen.sv
`timescale 1ns/1ps
module adp_gate_gen #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] lim_nxt_i,
  output logic             gate_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_o <= 1'b0;
    else         gate_o <= (cnt_nxt_i < lim_nxt_i);
  end
endmodule

// File: rtl/adp_skip_ctrl.sv
`timescale 1ns/1ps
module adp_skip_ctrl
  import adp_pkg::*;
#(
  parameter int STEP_CLKS = 5,
  parameter int MAX_CODE  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cycle_tick_i,
  input  logic [CODE_W-1:0] err_code_i,
  output logic              gate_o
);
  localparam int PERIOD_CLKS = DUTY_STEPS * STEP_CLKS;
  localparam int CNT_W       = $clog2(PERIOD_CLKS + 1);

  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] lim_nxt;

  adp_cycle_timer #(.PERIOD_CLKS(PERIOD_CLKS), .CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (cycle_tick_i),
    .cnt_nxt_o(cnt_nxt)
  );

  adp_duty_map #(.STEP_CLKS(STEP_CLKS), .MAX_CODE(MAX_CODE), .CNT_W(CNT_W)) u_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (cycle_tick_i),
    .code_i   (err_code_i),
    .lim_nxt_o(lim_nxt)
  );

  adp_gate_gen #(.CNT_W(CNT_W)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_nxt_i(cnt_nxt),
    .lim_nxt_i(lim_nxt),
    .gate_o   (gate_o)
  );
endmodule

// File: rtl/adp_skip_ctrl_chk.sv
`timescale 1ns/1ps
module adp_skip_ctrl_chk
  import adp_pkg::*;
#(
  parameter int STEP_CLKS = 5,
  parameter int MAX_CODE  = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cycle_tick_i,
  input logic [CODE_W-1:0] err_code_i,
  input logic              gate_o
);
  localparam int LIMIT = MAX_CODE * STEP_CLKS;

  logic seen_tick_q;
  int   hi_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_tick_q <= 1'b0;
      hi_run_q    <= 0;
    end else begin
      if (cycle_tick_i) seen_tick_q <= 1'b1;
      if (cycle_tick_i)                    hi_run_q <= 0;
      else if (gate_o && hi_run_q <= LIMIT) hi_run_q <= hi_run_q + 1;
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_tick_q |-> !gate_o);

  assert_pulse_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_tick_i && seen_tick_q && err_code_i != '0) |=> gate_o);

  assert_skip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_tick_i && seen_tick_q && err_code_i == '0) |=> !gate_o);

  assert_max_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> (hi_run_q < LIMIT));

  // R5 and R7: a rising edge needs a tick
  assert_no_mid_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_tick_i |=> !$rose(gate_o));

  assert_first_skip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_tick_i && !seen_tick_q) |=> !gate_o);
endmodule

bind adp_skip_ctrl adp_skip_ctrl_chk #(.STEP_CLKS(STEP_CLKS), .MAX_CODE(MAX_CODE)) u_chk (.*);

// File: tb/sim_adp_skip_ctrl.sv
`timescale 1ns/1ps
module sim_adp_skip_ctrl;
  localparam int STEP = 5;
  localparam int MAXC = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] code = 3'd0;
  logic       gate;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural model: remaining high clocks
  int rem = 0;
  bit armed = 1'b0;
  bit exp_gate = 1'b0;

  always #4 clk = ~clk;

  adp_skip_ctrl #(.STEP_CLKS(STEP), .MAX_CODE(MAXC)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cycle_tick_i(tick),
    .err_code_i  (code),
    .gate_o      (gate)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem = 0; armed = 1'b0; exp_gate = 1'b0;
    end else begin
      if (tick) begin
        rem = armed ? ((int'(code) > MAXC ? MAXC : int'(code)) * STEP) : 0;
        armed = 1'b1;
      end else if (rem > 0) begin
        rem = rem - 1;
      end
      exp_gate = (rem > 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp_v, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) check(gate == exp_gate, cur_req, int'(gate), int'(exp_gate));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // one switching cycle from a negedge; counts high samples
  task automatic run_cycle(input int c, input int len, input int mid, input int exp_w, input string req);
    int hi = 0;
    cur_req = req;
    tick = 1'b1;
    code = 3'(c);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (gate) hi++;
      if (i == 0) tick = 1'b0;
      if (i == 2 && mid >= 0) code = 3'(mid);
    end
    check(hi == exp_w, req, hi, exp_w);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(gate == 1'b0, "R1", int'(gate), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(gate == 1'b0, "R1", int'(gate), 0);

    run_cycle(7, 80, -1, 0, "R6");
    for (int c = 1; c <= 5; c++) run_cycle(c, 80, -1, c * STEP, "R2");
    run_cycle(0, 80, -1, 0, "R3");
    run_cycle(7, 80, -1, MAXC * STEP, "R4");
    run_cycle(6, 80, -1, MAXC * STEP, "R4");
    run_cycle(2, 80, 7, 2 * STEP, "R5");
    run_cycle(3, 80, 0, 3 * STEP, "R5");
    run_cycle(4, 200, -1, 4 * STEP, "R7");
    check(gate == 1'b0, "R7", int'(gate), 0);
    run_cycle(6, 10, -1, 10, "R8");
    run_cycle(2, 80, -1, 2 * STEP, "R8");

    // async reset in the middle of a pulse
    cur_req = "R1";
    tick = 1'b1; code = 3'd5;
    @(negedge clk); tick = 1'b0;
    repeat (4) @(negedge clk);
    check(gate == 1'b1, "R2", int'(gate), 1);
    #1 rst_n = 1'b0;
    #1 check(gate == 1'b0, "R1", int'(gate), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    run_cycle(5, 80, -1, 0, "R6");
    run_cycle(1, 80, -1, STEP, "R2");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule